// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block samples a set of interrupt request lines into a request register and decides which pending, unmasked request should be forwarded to the processor. Each line is set up on its own as either level-sensitive or edge-sensitive. Level lines simply follow their input. Edge lines latch a rising transition and then hold it.

Priority is rotating. A base offset names the line that currently ranks highest, and rank then rises upward from that line, wrapping past the top line. A request is forwarded only when it ranks strictly above every interrupt that is already in service.

The in-service set can be trimmed before the comparison in two ways. A nesting flag drops the cascade line when this unit acts as a master. A special-mask flag drops the in-service bits that are currently masked. Acknowledge, register programming and cascading live outside this block. The outputs are combinational from the registered request state, so a change on a request input reaches the outputs one clock later.

Top module: `rot_prio_resolver`

## Requirements
- R1: A line whose bit in `trig_level` is 1 (level mode) has its request bit equal to the input level sampled at the previous rising clock edge. It sets while the line is high and clears while the line is low.
- R2: A line whose bit in `trig_level` is 0 (edge mode) has its request bit set at a clock edge where the input is high and the previously sampled level was low. The bit stays set after the input falls.
- R3: A synchronous active-high `rst` clears the request bits and the remembered levels. During reset and right after it, `irq_valid` is 0. An edge-mode line that is already high when reset is released counts as a rising edge at the first clock edge after release.
- R4: A line whose `mask` bit is 1 is never the reported winner. When every pending line is masked, `irq_valid` is 0.
- R5: The winner is the first pending, unmasked line found by scanning from line `rot_base` upward, modulo 8. `irq_line` gives that line's number (0 to 7).
- R6: The in-service rank is found with the same rotated scan over `in_service`. `irq_valid` is 1 only when the winner's rank is strictly smaller than that rank. An equal rank gives 0. An empty in-service set never blocks.
- R7: When `nest_en` is 1 and the parameter IS_MASTER is 1, in-service bit CASCADE_LINE (default 2) is left out of the in-service rank.
- R8: When `smask_en` is 1, in-service bits whose `mask` bit is 1 are left out of the in-service rank.
- R9: With no pending unmasked request, `irq_valid` is 0 and `irq_line` is 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Raw interrupt request lines |
| trig_level | input | 8 | Per-line trigger select: 1 = level, 0 = edge |
| mask | input | 8 | Per-line mask, 1 = masked |
| in_service | input | 8 | Interrupts currently in service |
| rot_base | input | 3 | Line that holds top priority |
| nest_en | input | 1 | Ignore the cascade line in the in-service set |
| smask_en | input | 1 | Ignore masked lines in the in-service set |
| irq_valid | output | 1 | A request outranks everything in service |
| irq_line | output | 3 | Number of the winning line |

## Verification
Edge capture and level tracking can change the request register in the same clock. The case that matters is a level line that drops in the very cycle an edge line rises, so that the winner has to switch between lines with no gap and no stale result. The bench provokes this by driving both transitions at one falling edge with one line in each mode. It then checks, one clock later, that the edge line is reported and that raising the level line again takes the win back by rank.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/rpr_capture.sv
module rpr_capture #(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] req_in,
  input  logic [NLINES-1:0] trig_level,
  output logic [NLINES-1:0] pend_q
);
  import rpr_pkg::*;

  logic [NLINES-1:0] seen_q;
  logic [NLINES-1:0] pend_d;

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_line
      always_comb begin
        if (trig_e'(trig_level[i]) == TRIG_LEVEL)
          pend_d[i] = req_in[i];
        else
          pend_d[i] = pend_q[i] | (req_in[i] & ~seen_q[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      seen_q <= '0;
    end else begin
      pend_q <= pend_d;
      seen_q <= req_in;
    end
  end

  // R1: level lines mirror the previously sampled input
  assert_level_follow_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(trig_level)) == ($past(req_in) & $past(trig_level))));

  // R2: a rising edge on an edge line sets its request bit
  assert_edge_capture_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(~trig_level & req_in & ~seen_q)) ==
              $past(~trig_level & req_in & ~seen_q)));
endmodule

// File: rtl/rpr_rot_scan.sv
module rpr_rot_scan #(
  parameter int NLINES = 8,
  localparam int IDXW  = $clog2(NLINES)
) (
  input  logic [NLINES-1:0] vec,
  input  logic [IDXW-1:0]   base,
  output logic [IDXW:0]     rank,
  output logic [IDXW-1:0]   line,
  output logic              found
);
  always_comb begin
    rank  = (IDXW+1)'(NLINES);
    line  = '0;
    found = 1'b0;
    for (int p = NLINES - 1; p >= 0; p--) begin
      logic [IDXW-1:0] cand;
      cand = IDXW'(p) + base;
      if (vec[cand]) begin
        rank  = (IDXW+1)'(p);
        line  = cand;
        found = 1'b1;
      end
    end
  end

  // R5: a reported line is always a set bit of the scanned vector
  always_comb begin
    if (found) assert_scan_hit_R5: assert (vec[line]);
    else       assert_scan_none_R9: assert (vec == '0);
  end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
  parameter int NLINES       = 8,
  parameter int CASCADE_LINE = 2,
  parameter bit IS_MASTER    = 1'b1,
  localparam int IDXW        = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] req_in,
  input  logic [NLINES-1:0] trig_level,
  input  logic [NLINES-1:0] mask,
  input  logic [NLINES-1:0] in_service,
  input  logic [IDXW-1:0]   rot_base,
  input  logic              nest_en,
  input  logic              smask_en,
  output logic              irq_valid,
  output logic [IDXW-1:0]   irq_line
);
  logic [NLINES-1:0] pend_q;
  logic [NLINES-1:0] cand_set;
  logic [NLINES-1:0] isr_eff;
  logic [IDXW:0]     req_rank, isr_rank;
  logic [IDXW-1:0]   req_line, isr_line;
  logic              req_found, isr_found;

  rpr_capture #(.NLINES(NLINES)) u_cap (
    .clk(clk), .rst(rst), .req_in(req_in),
    .trig_level(trig_level), .pend_q(pend_q)
  );

  assign cand_set = pend_q & ~mask;

  always_comb begin
    isr_eff = in_service;
    if (smask_en) isr_eff = isr_eff & ~mask;
    if (IS_MASTER && nest_en) isr_eff[CASCADE_LINE] = 1'b0;
  end

  rpr_rot_scan #(.NLINES(NLINES)) u_req_scan (
    .vec(cand_set), .base(rot_base), .rank(req_rank),
    .line(req_line), .found(req_found)
  );

  rpr_rot_scan #(.NLINES(NLINES)) u_isr_scan (
    .vec(isr_eff), .base(rot_base), .rank(isr_rank),
    .line(isr_line), .found(isr_found)
  );

  assign irq_valid = req_found && (req_rank < isr_rank);
  assign irq_line  = irq_valid ? req_line : '0;

  // R4: the reported line is never masked and is pending
  assert_unmasked_win_R4: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (!mask[irq_line] && pend_q[irq_line]));

  // R6: an in-service line at the winner's own position always blocks
  assert_equal_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (req_found && isr_found && isr_line == req_line) |-> !irq_valid);

  // R9: nothing pending means no request and a zero line number
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (cand_set == '0) |-> (!irq_valid && irq_line == '0));
endmodule

// File: tb/sim_rot_prio_resolver.sv
module sim_rot_prio_resolver;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req_in, trig_level, mask, in_service;
  logic [2:0] rot_base;
  logic       nest_en, smask_en;
  logic       irq_valid;
  logic [2:0] irq_line;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rot_prio_resolver u0 (
    .clk(clk), .rst(rst), .req_in(req_in), .trig_level(trig_level),
    .mask(mask), .in_service(in_service), .rot_base(rot_base),
    .nest_en(nest_en), .smask_en(smask_en),
    .irq_valid(irq_valid), .irq_line(irq_line)
  );

  // tag[3:0] req[7:0] mask[7:0] isr[7:0] base[2:0] nest smask ev el[2:0]
  localparam int NV = 16;
  localparam logic [36:0] VEC [NV] = '{
    {4'd9, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // R9 idle
    {4'd5, 8'h01, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0}, // R5 plain
    {4'd5, 8'h81, 8'h00, 8'h00, 3'd1, 1'b0, 1'b0, 1'b1, 3'd7}, // R5 wrap
    {4'd5, 8'h24, 8'h00, 8'h00, 3'd3, 1'b0, 1'b0, 1'b1, 3'd5}, // R5
    {4'd5, 8'h24, 8'h00, 8'h00, 3'd6, 1'b0, 1'b0, 1'b1, 3'd2}, // R5 wrap
    {4'd4, 8'h0C, 8'h04, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 3'd3}, // R4
    {4'd4, 8'hFF, 8'hFF, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // R4 all masked
    {4'd6, 8'h10, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // R6 lower rank
    {4'd6, 8'h08, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // R6 equal
    {4'd6, 8'h04, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0, 1'b1, 3'd2}, // R6 higher
    {4'd7, 8'h10, 8'h00, 8'h04, 3'd0, 1'b1, 1'b0, 1'b1, 3'd4}, // R7 cascade ignored
    {4'd7, 8'h10, 8'h00, 8'h04, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // R7 off
    {4'd8, 8'h10, 8'h02, 8'h02, 3'd0, 1'b0, 1'b1, 1'b1, 3'd4}, // R8 masked isr ignored
    {4'd8, 8'h10, 8'h02, 8'h02, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0}, // R8 off
    {4'd6, 8'h01, 8'h00, 8'h80, 3'd7, 1'b0, 1'b0, 1'b0, 3'd0}, // R6 rotated block
    {4'd6, 8'h01, 8'h00, 8'h80, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0}  // R6 rotated pass
  };

  task automatic chk(input string tag, input logic ev, input logic [2:0] el);
    n_run++;
    if (irq_valid !== ev || irq_line !== el) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b line=%0d, expected valid=%0b line=%0d",
               tag, irq_valid, irq_line, ev, el);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step();
    step();
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; req_in = '0; trig_level = 8'hFF; mask = '0;
    in_service = '0; rot_base = '0; nest_en = 1'b0; smask_en = 1'b0;
    step();
    step();
    // R3: during reset with a level line high, no request
    @(negedge clk); req_in = 8'h10;
    step();
    chk("R3 in reset", 1'b0, 3'd0);
    @(negedge clk); rst = 1'b0; req_in = '0;
    step();
    chk("R3 after reset", 1'b0, 3'd0);

    // table walk, all lines level mode (R1 drives the capture)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_in     = VEC[i][32:25];
      mask       = VEC[i][24:17];
      in_service = VEC[i][16:9];
      rot_base   = VEC[i][8:6];
      nest_en    = VEC[i][5];
      smask_en   = VEC[i][4];
      step();
      chk($sformatf("R%0d vector %0d", VEC[i][36:33], i), VEC[i][3], VEC[i][2:0]);
    end

    // R1: level line clears when its input drops
    @(negedge clk);
    mask = '0; in_service = '0; rot_base = '0; nest_en = 0; smask_en = 0;
    req_in = 8'h40;
    step();
    chk("R1 level high", 1'b1, 3'd6);
    @(negedge clk); req_in = 8'h00;
    step();
    chk("R1 level low", 1'b0, 3'd0);

    // R2: edge capture is sticky
    @(negedge clk); trig_level = 8'h00;
    do_reset();
    req_in = 8'h40;
    step();
    chk("R2 rise", 1'b1, 3'd6);
    @(negedge clk); req_in = 8'h00;
    step();
    chk("R2 held after fall", 1'b1, 3'd6);

    // R3: edge line high across reset release counts as a rise
    @(negedge clk); rst = 1'b1; req_in = 8'h02;
    step();
    chk("R3 edge in reset", 1'b0, 3'd0);
    @(negedge clk); rst = 1'b0;
    step();
    chk("R3 edge at release", 1'b1, 3'd1);

    // R1 with R2: level line drops as an edge line rises in the same cycle
    @(negedge clk); trig_level = 8'h08; req_in = 8'h00;
    do_reset();
    req_in = 8'h08;
    step();
    chk("R1 level wins", 1'b1, 3'd3);
    @(negedge clk); req_in = 8'h20;
    step();
    chk("R2 edge takes over", 1'b1, 3'd5);
    @(negedge clk); req_in = 8'h28;
    step();
    chk("R5 level back by rank", 1'b1, 3'd3);
    @(negedge clk); mask = 8'h08;
    step();
    chk("R4 mask hands back", 1'b1, 3'd5);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule